// File: doc/BRIEF.md
# Write Leveling Delay Search Controller

This block runs the controller side of a write leveling calibration. It steps a programmable delay on the outgoing data strobe one tap at a time. After each step it fires a single strobe pulse, waits for the clock level that the memory captured with that pulse to come back on the data lines, and compares it with the level seen at the previous tap. The search ends at the first tap where the returned level goes from low to high. That tap aligns the strobe's rising edge with the memory clock's rising edge.

A start pulse launches the search from tap 0. The block first raises a leveling-mode request and waits for an acknowledge. The request stands for the mode register write and the special termination setup, which are handled elsewhere. When the search ends, by finding the edge or by reaching the last tap, the block drops the request and waits for the acknowledge to fall. It then shows done, plus fail if no edge was found, and keeps the final tap on its delay output until the next start. The data feedback is the OR of all bits of the byte lane and passes through a two-flop synchronizer. After each pulse the block waits a fixed settle time before it samples.

States and transitions:
- IDLE goes to ENTER on start.
- ENTER goes to PULSE when the acknowledge is high.
- PULSE goes to WAIT after one cycle.
- WAIT goes to SAMPLE once the settle count expires.
- SAMPLE goes to EXIT on a low-to-high change or at the last tap, and to STEP otherwise.
- STEP goes to PULSE.
- EXIT goes to DONE when the acknowledge is low.
- DONE goes to ENTER on start.

Top module: `wlvl_search_ctrl`

## Requirements
- R1: After reset the block is idle with `tap_o` = 0 and `lvl_req_o`, `dqs_pulse_o`, `busy_o`, `done_o` and `fail_o` all low.
- R2: A start pulse while idle or done raises `lvl_req_o` in the next cycle. No strobe pulse is issued until `lvl_ack_i` has been seen high, and `dqs_pulse_o` is only ever high while `lvl_req_o` is high.
- R3: `dqs_pulse_o` is high for exactly one cycle per tap. The first pulse is at tap 0.
- R4: During a search `tap_o` only ever increases by exactly one. Each new value appears in the same cycle as its strobe pulse.
- R5: Consecutive strobe pulses are exactly SETTLE_CYC+3 cycles apart (pulse, SETTLE_CYC settle cycles, sample, step).
- R6: The feedback level is the OR of all `dq_fb_i` bits. A single high bit in any position counts as level 1.
- R7: The sample at tap 0 only records the reference level. The search stops at the first tap whose level is 1 while the previous tap's level was 0. That tap is reported on `tap_o` with `fail_o` low. A 1-to-0 change does not stop the search.
- R8: If tap 127 (the 7-bit maximum) is sampled with no low-to-high change, the block reports `fail_o` high with `tap_o` = 127. It never wraps the tap count.
- R9: After the search ends `lvl_req_o` falls, and `done_o` rises only after `lvl_ack_i` is low. `done_o` is never high while `lvl_req_o` is high.
- R10: `done_o`, `fail_o` and `tap_o` hold until the next start. A start clears `done_o` and `fail_o` in the next cycle. A start during a search is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start request (one-cycle pulse) |
| lvl_ack_i | input | 1 | Leveling mode / termination acknowledge |
| dq_fb_i | input | DQ_W | Asynchronous clock-level feedback from the byte lane |
| lvl_req_o | output | 1 | Request leveling mode and termination setup |
| tap_o | output | TAP_W | Delay tap for the strobe delay line |
| dqs_pulse_o | output | 1 | One-cycle strobe pulse request |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished |
| fail_o | output | 1 | No edge found (valid with done) |

## Verification
Every cycle, the assertions check the following:
- strobe pulses are single-cycle and only issued under the leveling request;
- the tap moves up by exactly one at a time and never wraps past the maximum;
- done never overlaps the request;
- done holds until a start;
- fail appears only with the last tap.

Only the bench's scenarios can show that the reported tap is the first low-to-high change. The same holds for the following:
- a high-to-low change is skipped;
- a lone feedback bit in any lane counts;
- the pulse spacing equals the settle time plus three;
- a start during a search leaves the result untouched.

// File: rtl/wlvl_pkg.sv
package wlvl_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ENTER,
        ST_PULSE,
        ST_WAIT,
        ST_SAMPLE,
        ST_STEP,
        ST_EXIT,
        ST_DONE
    } wlvl_state_t;
endpackage

// File: rtl/wlvl_fb_sync.sv
module wlvl_fb_sync #(
    parameter int DQ_W = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DQ_W-1:0] dq_i,
    output logic            level_o
);
    logic meta_q;
    logic sync_q;

    // Any lane bit high means the sampled clock level is high (R6)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= |dq_i;
            sync_q <= meta_q;
        end
    end

    assign level_o = sync_q;
endmodule

// File: rtl/wlvl_settle_timer.sv
module wlvl_settle_timer #(
    parameter int SETTLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load_i,
    output logic expired_o
);
    localparam int CW = (SETTLE_CYC < 2) ? 1 : $clog2(SETTLE_CYC);
    localparam logic [CW-1:0] LOAD_VAL = CW'(SETTLE_CYC - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= LOAD_VAL;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/wlvl_tap_ctr.sv
module wlvl_tap_ctr #(
    parameter int TAP_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [TAP_W-1:0] tap_o,
    output logic             at_max_o
);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    logic [TAP_W-1:0] tap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tap_q <= '0;
        end else if (clr_i) begin
            tap_q <= '0;
        end else if (inc_i) begin
            tap_q <= tap_q + 1'b1;
        end
    end

    assign tap_o    = tap_q;
    assign at_max_o = (tap_q == TAP_MAX);

    AST_TAP_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        inc_i |-> !at_max_o); // R8
endmodule

// File: rtl/wlvl_search_ctrl.sv
module wlvl_search_ctrl
    import wlvl_pkg::*;
#(
    parameter int DQ_W       = 8,
    parameter int TAP_W      = 7,
    parameter int SETTLE_CYC = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             lvl_ack_i,
    input  logic [DQ_W-1:0]  dq_fb_i,
    output logic             lvl_req_o,
    output logic [TAP_W-1:0] tap_o,
    output logic             dqs_pulse_o,
    output logic             busy_o,
    output logic             done_o,
    output logic             fail_o
);
    localparam logic [TAP_W-1:0] TAP_MAX = {TAP_W{1'b1}};

    wlvl_state_t state_q, state_d;

    logic fb_level;
    logic settle_done;
    logic at_max;
    logic start_ok;
    logic tap_clr;
    logic tap_inc;
    logic timer_load;
    logic rise_seen;

    logic prev_q;
    logic first_q;
    logic fail_q;

    wlvl_fb_sync #(.DQ_W(DQ_W)) i_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .dq_i    (dq_fb_i),
        .level_o (fb_level)
    );

    wlvl_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (timer_load),
        .expired_o (settle_done)
    );

    wlvl_tap_ctr #(.TAP_W(TAP_W)) i_tap (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (tap_clr),
        .inc_i    (tap_inc),
        .tap_o    (tap_o),
        .at_max_o (at_max)
    );

    // Start accepted only when no search is running (R10)
    assign start_ok   = start_i && (state_q == ST_IDLE || state_q == ST_DONE);
    assign tap_clr    = start_ok;
    assign tap_inc    = (state_q == ST_STEP);
    assign timer_load = (state_q == ST_PULSE);
    // Low-to-high change against the previous tap's level (R7)
    assign rise_seen  = !first_q && !prev_q && fb_level;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_ok) state_d = ST_ENTER;
            ST_ENTER:  if (lvl_ack_i) state_d = ST_PULSE;
            ST_PULSE:  state_d = ST_WAIT;
            ST_WAIT:   if (settle_done) state_d = ST_SAMPLE;
            ST_SAMPLE: begin
                if (rise_seen || at_max) state_d = ST_EXIT;
                else                     state_d = ST_STEP;
            end
            ST_STEP:   state_d = ST_PULSE;
            ST_EXIT:   if (!lvl_ack_i) state_d = ST_DONE;
            ST_DONE:   if (start_ok) state_d = ST_ENTER;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Search data registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            first_q <= 1'b1;
            fail_q  <= 1'b0;
        end else if (start_ok) begin
            prev_q  <= 1'b0;
            first_q <= 1'b1;
            fail_q  <= 1'b0;
        end else if (state_q == ST_SAMPLE) begin
            prev_q  <= fb_level;
            first_q <= 1'b0;
            fail_q  <= !rise_seen && at_max;
        end
    end

    // Outputs decoded from state
    always_comb begin
        lvl_req_o   = 1'b0;
        dqs_pulse_o = 1'b0;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        fail_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ENTER, ST_WAIT, ST_SAMPLE, ST_STEP: begin
                lvl_req_o = 1'b1;
                busy_o    = 1'b1;
            end
            ST_PULSE: begin
                lvl_req_o   = 1'b1;
                busy_o      = 1'b1;
                dqs_pulse_o = 1'b1;
            end
            ST_EXIT:  busy_o = 1'b1;
            ST_DONE: begin
                done_o = 1'b1;
                fail_o = fail_q;
            end
            default: ;
        endcase
    end

    AST_PULSE_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse_o |-> lvl_req_o); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        dqs_pulse_o |=> !dqs_pulse_o); // R3
    AST_TAP_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (lvl_req_o && $past(lvl_req_o) && !$stable(tap_o)) |->
            (dqs_pulse_o && tap_o == $past(tap_o) + 1'b1)); // R4
    AST_FAIL_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> (done_o && tap_o == TAP_MAX)); // R8
    AST_DONE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!lvl_req_o && !lvl_ack_i)); // R9
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(tap_o) && $stable(fail_o))); // R10
endmodule

// File: tb/test_wlvl_search_ctrl.sv
module test_wlvl_search_ctrl;
    localparam int DQ_W       = 8;
    localparam int TAP_W      = 7;
    localparam int SETTLE_CYC = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             lvl_ack_i;
    logic [DQ_W-1:0]  dq_fb_i;
    logic             lvl_req_o;
    logic [TAP_W-1:0] tap_o;
    logic             dqs_pulse_o;
    logic             busy_o;
    logic             done_o;
    logic             fail_o;

    int errors = 0;
    int checks = 0;

    // Memory model knobs: level 1 when tap >= rise_at or tap < high_below
    int rise_at    = 200;
    int high_below = 0;
    int lane       = 0;

    logic [2:0] ack_sh = 3'b000;
    int cyc = 0;
    int pulses = 0;
    int last_pulse = -1;
    int gap_min = 1 << 30;
    int gap_max = 0;

    always #10 clk = ~clk;

    wlvl_search_ctrl #(.DQ_W(DQ_W), .TAP_W(TAP_W), .SETTLE_CYC(SETTLE_CYC)) i_wlvl_search_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .lvl_ack_i   (lvl_ack_i),
        .dq_fb_i     (dq_fb_i),
        .lvl_req_o   (lvl_req_o),
        .tap_o       (tap_o),
        .dqs_pulse_o (dqs_pulse_o),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .fail_o      (fail_o)
    );

    // Acknowledge follows the request three cycles late
    always @(posedge clk) ack_sh <= {ack_sh[1:0], lvl_req_o};
    assign lvl_ack_i = ack_sh[2];

    always_comb begin
        dq_fb_i = '0;
        if (int'(tap_o) >= rise_at || int'(tap_o) < high_below)
            dq_fb_i[lane] = 1'b1;
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (dqs_pulse_o) begin
            pulses <= pulses + 1;
            if (last_pulse >= 0) begin
                if (cyc - last_pulse < gap_min) gap_min <= cyc - last_pulse;
                if (cyc - last_pulse > gap_max) gap_max <= cyc - last_pulse;
            end
            last_pulse <= cyc;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic clear_stats();
        pulses = 0;
        last_pulse = -1;
        gap_min = 1 << 30;
        gap_max = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk) start_i = 1'b1;
        @(negedge clk) start_i = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done_o && n < 20000) begin
            @(negedge clk);
            n++;
        end
        if (!done_o) begin
            errors++;
            checks++;
            $display("FAIL watchdog: done never rose");
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1", "tap after reset", int'(tap_o), 0);
        check("R1", "outputs after reset",
              int'({lvl_req_o, dqs_pulse_o, busy_o, done_o, fail_o}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_search(input string name, input int r, input int hb, input int ln,
                            input int exp_tap, input bit exp_fail);
        rise_at = r; high_below = hb; lane = ln;
        clear_stats();
        pulse_start();
        check("R2", {name, " request after start"}, int'(lvl_req_o), 1);
        check("R10", {name, " done cleared by start"}, int'(done_o || fail_o), 0);
        check("R2", {name, " no pulse before ack"}, pulses, 0);
        wait_done();
        check(exp_fail ? "R8" : "R7", {name, " tap"}, int'(tap_o), exp_tap);
        check(exp_fail ? "R8" : "R7", {name, " fail"}, int'(fail_o), int'(exp_fail));
        check("R3", {name, " pulse count"}, pulses, exp_tap + 1);
        if (pulses > 1) begin
            check("R5", {name, " min gap"}, gap_min, SETTLE_CYC + 3);
            check("R5", {name, " max gap"}, gap_max, SETTLE_CYC + 3);
        end
        check("R9", {name, " req/ack low at done"}, int'(lvl_req_o || lvl_ack_i), 0);
    endtask

    task automatic t_hold();
        logic [TAP_W-1:0] t0;
        logic f0;
        t0 = tap_o;
        f0 = fail_o;
        rise_at = 0;
        repeat (60) @(negedge clk);
        check("R10", "done held", int'(done_o), 1);
        check("R10", "tap held", int'(tap_o), int'(t0));
        check("R10", "fail held", int'(fail_o), int'(f0));
    endtask

    task automatic t_busy_start();
        rise_at = 20; high_below = 0; lane = 2;
        clear_stats();
        pulse_start();
        repeat (100) @(negedge clk);
        pulse_start();
        wait_done();
        check("R10", "start during search ignored: tap", int'(tap_o), 20);
        check("R10", "start during search ignored: pulses", pulses, 21);
    endtask

    initial begin
        t_reset();
        t_search("edge40_skip_fall", 40, 10, 0, 40, 1'b0);
        t_hold();
        t_search("edge1", 1, 0, 3, 1, 1'b0);
        t_search("lane7_edge63", 63, 0, 7, 63, 1'b0);
        check("R6", "single bit lane 7 detected", int'(fail_o), 0);
        t_search("edge127", 127, 0, 1, 127, 1'b0);
        t_search("never_rises", 200, 0, 0, 127, 1'b1);
        t_search("always_high", 0, 0, 4, 127, 1'b1);
        t_busy_start();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(20 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: global timeout");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule